// File: doc/BRIEF.md
# Signed/Unsigned Radix-4 Booth Multiplier

This block multiplies two 8-bit operands and returns a 16-bit product. A single mode input tells it how to read the operands. When the input is low, both operands are unsigned values from 0 to 255. When it is high, both are two's-complement values from -128 to +127. The mode works by widening each operand by two bits before the array sees it. In unsigned mode the two new bits are zero; in signed mode they copy bit 7. As a result, one radix-4 array serves both number formats.

The widened multiplier is split into five overlapping three-bit groups. Each group picks a multiple of the widened multiplicand: 0, ±1 or ±2. Every partial-product row has its own bit cells, and each cell decodes its group by itself, so there is no shared encoder stage. A negative multiple is built as an inverted row plus one correction bit at that row's lowest weight. Each correction bit sits in a free low position of the next row. Three 3:2 carry-save stages reduce the five rows to two vectors. A carry-lookahead adder then adds those two vectors, and the sum is held in an output register.

Top module: `smul_booth_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `product` becomes 0 at that edge.
- R2: `product` is registered. After each rising edge it shows the result for the operands and mode sampled at that edge, and it stays unchanged while those inputs stay unchanged.
- R3: With `is_signed` = 0, `product` equals `op_a` × `op_b`, with both operands read as unsigned (result range 0 to 65025).
- R4: With `is_signed` = 1, `product` equals `op_a` × `op_b` as a 16-bit two's-complement value, with both operands read as two's complement.
- R5: For all-ones operands (0xFF × 0xFF), the product is 0xFE01 in unsigned mode and 0x0001 in signed mode.
- R6: At the range limits: signed -128 × +127 gives 0xC080, signed -128 × -128 gives 0x4000, unsigned 128 × 128 gives 0x4000, and unsigned 127 × 127 gives 0x3F01.
- R7: When either operand is zero, the product is zero in both modes.
- R8: If only `is_signed` changes, the new reading applies from the next edge. For example, 0x80 × 0x01 gives 0x0080 in unsigned mode and 0xFF80 in signed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the product |
| op_a | input | 8 | Multiplicand |
| op_b | input | 8 | Multiplier, Booth recoded |
| is_signed | input | 1 | 0 = unsigned operands, 1 = two's-complement operands |
| product | output | 16 | Registered 16-bit product |

## Verification
On every cycle, the bound checker compares the registered product with a plain multiply of the operands held one cycle earlier, in each mode. It also checks that reset clears the output, that a zero operand gives zero, and that steady inputs keep the output steady. In addition, it confirms that the top Booth digit is never negative, which is why four correction bits are enough. Only the bench scenarios show the exact timing of a mode flip, the moment a mid-run reset takes effect, and the named values at the range limits. The exhaustive sweep over every operand pair in both modes is likewise done only in the bench.

// File: rtl/smul_pkg.sv
`timescale 1ns/1ps
package smul_pkg;

  // Control lines selected by one three-bit group of the multiplier
  typedef struct packed {
    logic one;   // pick multiplicand
    logic two;   // pick multiplicand shifted left by one
    logic neg;   // invert and add a correction bit
  } booth_sel_t;

  // trip = {b[2i+1], b[2i], b[2i-1]}
  function automatic booth_sel_t booth_decode(input logic [2:0] trip);
    booth_sel_t s;
    s.one = trip[1] ^ trip[0];
    s.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
    s.neg = trip[2] & ~(trip[1] & trip[0]);
    return s;
  endfunction

endpackage

// File: rtl/smul_booth_row.sv
`timescale 1ns/1ps
// One partial-product row; each bit cell decodes the group itself.
module smul_booth_row #(
  parameter int ROW_W = 16
) (
  input  logic [2:0]       trip,
  input  logic [ROW_W-1:0] mcand,
  output logic [ROW_W-1:0] row,
  output logic             neg
);
  import smul_pkg::*;

  booth_sel_t sel_row;
  assign sel_row = booth_decode(trip);
  assign neg     = sel_row.neg;

  for (genvar j = 0; j < ROW_W; j++) begin : g_cell
    booth_sel_t sel_c;
    logic       x_lo;
    assign sel_c = booth_decode(trip);
    if (j == 0) begin : g_lsb
      assign x_lo = 1'b0;
    end else begin : g_mid
      assign x_lo = mcand[j-1];
    end
    assign row[j] = ((sel_c.one & mcand[j]) | (sel_c.two & x_lo)) ^ sel_c.neg;
  end

endmodule

// File: rtl/smul_csa.sv
`timescale 1ns/1ps
// 3:2 carry-save stage; the carry vector comes out already shifted by one.
module smul_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  assign carry[0] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_bit
    assign sum[j] = in_a[j] ^ in_b[j] ^ in_c[j];
    if (j < W - 1) begin : g_cy
      assign carry[j+1] = (in_a[j] & in_b[j]) | (in_a[j] & in_c[j]) | (in_b[j] & in_c[j]);
    end
  end

endmodule

// File: rtl/smul_cla.sv
`timescale 1ns/1ps
// Carry-lookahead adder, modulo 2^W: full lookahead inside each group,
// group carries chained between groups.
module smul_cla #(
  parameter int W   = 16,
  parameter int GRP = 4
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] sum
);
  localparam int NG = W / GRP;

  logic [W-1:0]  gen, prop;
  logic [NG-1:0] gcar;

  assign gen     = in_a & in_b;
  assign prop    = in_a ^ in_b;
  assign gcar[0] = 1'b0;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    logic [GRP-1:0] gg, pp, cc;
    assign gg = gen[gi*GRP +: GRP];
    assign pp = prop[gi*GRP +: GRP];

    always_comb begin
      logic term;
      for (int k = 0; k < GRP; k++) begin
        cc[k] = gcar[gi];
        for (int m = 0; m < k; m++) cc[k] = cc[k] & pp[m];
        for (int m = 0; m < k; m++) begin
          term = gg[m];
          for (int q = m + 1; q < k; q++) term = term & pp[q];
          cc[k] = cc[k] | term;
        end
      end
    end

    assign sum[gi*GRP +: GRP] = pp ^ cc;

    if (gi < NG - 1) begin : g_out
      assign gcar[gi+1] = gg[GRP-1] | (pp[GRP-1] & cc[GRP-1]);
    end
  end

endmodule

// File: rtl/smul_booth_top.sv
`timescale 1ns/1ps
module smul_booth_top #(
  parameter int OPW = 8,
  parameter int GRP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  input  logic             is_signed,
  output logic [2*OPW-1:0] product
);
  localparam int EXTW = OPW + 2;
  localparam int ND   = EXTW / 2;
  localparam int PW   = 2 * OPW;

  logic [EXTW-1:0] ext_a, ext_b;
  logic [EXTW:0]   mplr_z;
  logic [PW-1:0]   mcand;
  logic [PW-1:0]   row_raw [ND];
  logic [PW-1:0]   rows    [ND];
  logic [ND-1:0]   neg_vec;

  // Mode-dependent widening by two bits
  assign ext_a  = {{2{is_signed & op_a[OPW-1]}}, op_a};
  assign ext_b  = {{2{is_signed & op_b[OPW-1]}}, op_b};
  assign mcand  = {{(PW-EXTW){ext_a[EXTW-1]}}, ext_a};
  assign mplr_z = {ext_b, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_row
    smul_booth_row #(.ROW_W(PW)) u_row (
      .trip  (mplr_z[2*i+2 -: 3]),
      .mcand (mcand),
      .row   (row_raw[i]),
      .neg   (neg_vec[i])
    );
    if (i == 0) begin : g_first
      assign rows[i] = row_raw[i];
    end else begin : g_next
      // previous row's correction bit fills a free low slot of this row
      assign rows[i] = (row_raw[i] << (2*i)) | (PW'(neg_vec[i-1]) << (2*i-2));
    end
  end

  logic [PW-1:0] s1, c1, s2, c2, s3, c3, total;

  smul_csa #(.W(PW)) u_csa1 (.in_a(rows[0]), .in_b(rows[1]), .in_c(rows[2]), .sum(s1), .carry(c1));
  smul_csa #(.W(PW)) u_csa2 (.in_a(rows[3]), .in_b(rows[4]), .in_c(s1),      .sum(s2), .carry(c2));
  smul_csa #(.W(PW)) u_csa3 (.in_a(c1),      .in_b(s2),      .in_c(c2),      .sum(s3), .carry(c3));

  smul_cla #(.W(PW), .GRP(GRP)) u_cla (.in_a(s3), .in_b(c3), .sum(total));

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= total;
  end

endmodule

// File: rtl/smul_booth_chk.sv
`timescale 1ns/1ps
module smul_booth_chk #(
  parameter int OPW = 8,
  parameter int ND  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [OPW-1:0]   op_a,
  input logic [OPW-1:0]   op_b,
  input logic             is_signed,
  input logic [2*OPW-1:0] product,
  input logic [ND-1:0]    neg_vec
);
  localparam int PW = 2 * OPW;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> product == '0);

  p_stable_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(op_a) && $stable(op_b) && $stable(is_signed)) |=> $stable(product));

  p_unsigned_match_r3: assert property (@(posedge clk) disable iff (rst)
    !is_signed |=> product == PW'({{OPW{1'b0}}, $past(op_a)} * {{OPW{1'b0}}, $past(op_b)}));

  p_signed_match_r4: assert property (@(posedge clk) disable iff (rst)
    is_signed |=> product == PW'({{OPW{$past(op_a[OPW-1])}}, $past(op_a)} *
                                 {{OPW{$past(op_b[OPW-1])}}, $past(op_b)}));

  // R4: the most significant digit is never negative, so its correction bit is not needed
  p_top_digit_nonneg_r4: assert property (@(posedge clk) disable iff (rst) !neg_vec[ND-1]);

  p_zero_operand_r7: assert property (@(posedge clk) disable iff (rst)
    (op_a == '0 || op_b == '0) |=> product == '0);

endmodule

bind smul_booth_top smul_booth_chk #(.OPW(OPW), .ND(ND)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
  .is_signed(is_signed), .product(product), .neg_vec(neg_vec)
);

// File: tb/tb_smul_booth_top.sv
`timescale 1ns/1ps
module tb_smul_booth_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  op_a, op_b;
  logic        is_signed;
  logic [15:0] product;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 0;

  smul_booth_top dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .is_signed(is_signed), .product(product)
  );

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [15:0] ref_mul(logic [7:0] a, logic [7:0] b, logic s);
    if (s) return 16'({{8{a[7]}}, a} * {{8{b[7]}}, b});
    return 16'({8'h00, a} * {8'h00, b});
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: product=0x%04h expected=0x%04h", req, got, exp);
    end
  endtask

  // drive at a falling edge, result visible at the next falling edge
  task automatic apply(logic [7:0] a, logic [7:0] b, logic s);
    op_a = a; op_b = b; is_signed = s;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    check("R1", product, 16'h0000);
  endtask

  task automatic t_latency;
    apply(8'd5, 8'd7, 1'b0);
    check("R2", product, 16'd35);
    op_a = 8'd9; op_b = 8'd9;
    #1;
    check("R2", product, 16'd35);      // no edge yet: old value held
    @(negedge clk);
    check("R2", product, 16'd81);
    @(negedge clk);
    check("R2", product, 16'd81);      // steady inputs, steady output
  endtask

  task automatic t_all_ones;
    apply(8'hFF, 8'hFF, 1'b0); check("R5", product, 16'hFE01);
    apply(8'hFF, 8'hFF, 1'b1); check("R5", product, 16'h0001);
    apply(8'hFF, 8'h01, 1'b1); check("R4", product, 16'hFFFF);
  endtask

  task automatic t_extremes;
    apply(8'h80, 8'h7F, 1'b1); check("R6", product, 16'hC080);
    apply(8'h80, 8'h80, 1'b1); check("R6", product, 16'h4000);
    apply(8'h80, 8'h80, 1'b0); check("R6", product, 16'h4000);
    apply(8'h7F, 8'h7F, 1'b0); check("R6", product, 16'h3F01);
  endtask

  task automatic t_zero;
    apply(8'h00, 8'hFF, 1'b1); check("R7", product, 16'h0000);
    apply(8'hA5, 8'h00, 1'b0); check("R7", product, 16'h0000);
    apply(8'h00, 8'h80, 1'b0); check("R7", product, 16'h0000);
  endtask

  task automatic t_mode_switch;
    apply(8'h80, 8'h01, 1'b0); check("R8", product, 16'h0080);
    apply(8'h80, 8'h01, 1'b1); check("R8", product, 16'hFF80);
    apply(8'h80, 8'h01, 1'b0); check("R8", product, 16'h0080);
  endtask

  task automatic t_reset_midstream;
    apply(8'hC3, 8'h5A, 1'b0);
    check("R3", product, ref_mul(8'hC3, 8'h5A, 1'b0));
    rst = 1'b1;
    @(negedge clk);
    check("R1", product, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", product, ref_mul(8'hC3, 8'h5A, 1'b0));
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          apply(8'(a), 8'(b), 1'(s));
          check(s ? "R4" : "R3", product, ref_mul(8'(a), 8'(b), 1'(s)));
        end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    rst = 1'b1; op_a = '0; op_b = '0; is_signed = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state;
    rst = 1'b0;
    @(negedge clk);
    t_latency;
    t_all_ones;
    t_extremes;
    t_zero;
    t_mode_switch;
    t_reset_midstream;
    t_sweep;
    done = 1;
    summary;
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary;
      $finish;
    end
  end

endmodule